// File: doc/BRIEF.md
# Auto-Restart Fault Supervisor

This block sequences supply start-up and fault handling for an offline switching power controller. Analog comparators outside the block reduce the supply rail, the feedback node and the die temperature to single-bit flags. From these the block decides whether the power switch may be driven and whether the high-voltage start-up current source should charge the supply capacitor.

The block is a three-state machine. `ST_CHARGE` is the under-voltage lockout state: the start-up source is on and switching is off. `ST_RUN` drives switching, with the start-up source off. `ST_HALT` is the latched-fault state: switching and the start-up source are both off, so the supply decays. The transitions are:
- start (`ST_CHARGE`→`ST_RUN`)
- thermal hold (`ST_CHARGE`→`ST_HALT`), taken when a thermal lock is pending
- UVLO drop (`ST_RUN`→`ST_CHARGE`)
- trip (`ST_RUN`→`ST_HALT`)
- collapse (`ST_HALT`→`ST_CHARGE`)

A fault never clears while the part runs. Only a full collapse and recharge of the supply releases it, and thermal faults additionally need a cooled indication.

A small status register keeps the cause of the trip until the next successful start, so the cause can still be read after the supply has cycled.

Top module: `restart_supervisor`

## Requirements
- R1: After reset the block is in `ST_CHARGE`: `startup_en`=1, `switch_en`=0, `halted`=0, `fault_code`=0, and the thermal lock is clear.
- R2: In `ST_CHARGE`, `vcc_start`=1 with no thermal lock moves to `ST_RUN` at the next clock edge: `switch_en`=1 and `startup_en`=0.
- R3: In `ST_RUN`, `vcc_stop`=1 with no fault flag returns to `ST_CHARGE`. If a fault flag is high in the same cycle, the trip (R4) takes precedence.
- R4: In `ST_RUN`, any of `fb_overload`, `vcc_ovp`, `over_current`, `out_short` or `temp_hot` moves to `ST_HALT` at the next edge: `switch_en`=0, `startup_en`=0, `halted`=1.
- R5: `ST_HALT` is held while `vcc_stop`=0, even after every fault flag has dropped. `vcc_stop`=1 moves to `ST_CHARGE`.
- R6: On a trip, `fault_code` takes the cause of the trip. The encoding is: 1 overload, 2 over-voltage, 3 over-current, 4 output short, 5 thermal. When several flags are high together, the priority is thermal > over-voltage > over-current > output short > overload.
- R7: `fault_code` clears to 0 only on the start transition and is otherwise held. Flags raised while in `ST_HALT` do not change it.
- R8: The non-thermal fault flags have no effect in `ST_CHARGE` or `ST_HALT`.
- R9: `temp_hot` sets a thermal lock in any state. The lock clears only when `temp_cooled`=1 while `temp_hot`=0. In `ST_CHARGE`, `vcc_start`=1 with the lock set takes the thermal-hold transition to `ST_HALT` instead of starting. If `fault_code` is 0 at that point, it becomes 5.
- R10: `switch_en` and `startup_en` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_start | input | 1 | Supply at or above the start threshold |
| vcc_stop | input | 1 | Supply at or below the stop threshold |
| vcc_ovp | input | 1 | Supply over-voltage flag |
| fb_overload | input | 1 | Feedback node at the overload shutdown level |
| over_current | input | 1 | Abnormal over-current flag |
| out_short | input | 1 | Output short detected |
| temp_hot | input | 1 | Die above the shutdown temperature |
| temp_cooled | input | 1 | Die has fallen by the recovery hysteresis |
| switch_en | output | 1 | Power switch may be driven |
| startup_en | output | 1 | High-voltage start-up source enabled |
| halted | output | 1 | Fault latched, waiting for supply collapse |
| fault_code | output | 3 | Cause of the last trip (R6 encoding) |

## Verification
Every flag is sampled at a clock edge and acts on the state register and on the status register in that same edge. The outputs decode the state directly, so each result is due exactly one edge after its stimulus. The thermal lock is also a register, so a cooled pulse needs one edge before a start can use it. The bench drives inputs on the falling edge and checks on the next falling edge, so every check sits one rising edge after its cause. The R5 and R8 checks hold their stimulus for several such steps and confirm after each one that nothing moved.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic [1:0] {
        ST_CHARGE = 2'd0,
        ST_RUN    = 2'd1,
        ST_HALT   = 2'd2
    } sup_state_t;

    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        FC_NONE     = 3'd0,
        FC_OVERLOAD = 3'd1,
        FC_OVERVOLT = 3'd2,
        FC_OVERCUR  = 3'd3,
        FC_SHORT    = 3'd4,
        FC_THERMAL  = 3'd5
    } fault_code_t;

endpackage

// File: rtl/rsup_fault_prio.sv
module rsup_fault_prio
    import rsup_pkg::*;
(
    input  logic        fb_overload,
    input  logic        vcc_ovp,
    input  logic        over_current,
    input  logic        out_short,
    input  logic        temp_hot,
    output logic        any_fault,
    output fault_code_t cause
);
    // R6: thermal > over-voltage > over-current > short > overload
    always_comb begin
        if (temp_hot)          cause = FC_THERMAL;
        else if (vcc_ovp)      cause = FC_OVERVOLT;
        else if (over_current) cause = FC_OVERCUR;
        else if (out_short)    cause = FC_SHORT;
        else if (fb_overload)  cause = FC_OVERLOAD;
        else                   cause = FC_NONE;
    end

    assign any_fault = temp_hot | vcc_ovp | over_current | out_short | fb_overload;

    always_comb begin
        a_r6_cause_nonzero: assert (any_fault == (cause != FC_NONE))
            else $error("R6: cause does not match fault presence");
    end
endmodule

// File: rtl/rsup_therm_lock.sv
module rsup_therm_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic temp_hot,
    input  logic temp_cooled,
    output logic lock
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     lock <= 1'b0;
        else if (temp_hot)              lock <= 1'b1;
        else if (temp_cooled)           lock <= 1'b0;
    end

    // R9: a hot flag always leaves the lock set
    a_r9_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
        temp_hot |=> lock);
    // R9: without a cooled indication the lock never falls
    a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !temp_cooled) |=> lock);
endmodule

// File: rtl/rsup_fsm.sv
module rsup_fsm
    import rsup_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vcc_start,
    input  logic        vcc_stop,
    input  logic        any_fault,
    input  fault_code_t cause,
    input  logic        therm_lock,
    output sup_state_t  state,
    output fault_code_t code_q
);
    sup_state_t state_d;

    // next-state decision
    always_comb begin
        state_d = state;
        unique case (state)
            ST_CHARGE: if (vcc_start) state_d = therm_lock ? ST_HALT : ST_RUN;
            ST_RUN: begin
                if (any_fault)     state_d = ST_HALT;
                else if (vcc_stop) state_d = ST_CHARGE;
            end
            ST_HALT:   if (vcc_stop) state_d = ST_CHARGE;
            default:   state_d = ST_CHARGE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CHARGE;
        else        state <= state_d;
    end

    // fault status register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= FC_NONE;
        end else if (state == ST_RUN && state_d == ST_HALT) begin
            code_q <= cause;
        end else if (state == ST_CHARGE && state_d == ST_RUN) begin
            code_q <= FC_NONE;
        end else if (state == ST_CHARGE && state_d == ST_HALT && code_q == FC_NONE) begin
            code_q <= FC_THERMAL;
        end
    end

    a_r2_no_start_without_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHARGE && !vcc_start) |=> state != ST_RUN);
    a_r4_fault_trips: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && any_fault) |=> state == ST_HALT);
    a_r5_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !vcc_stop) |=> state == ST_HALT);
    a_r7_code_held_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> $stable(code_q));
    a_r9_lock_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHARGE && therm_lock) |=> state != ST_RUN);
endmodule

// File: rtl/restart_supervisor.sv
module restart_supervisor
    import rsup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vcc_start,
    input  logic              vcc_stop,
    input  logic              vcc_ovp,
    input  logic              fb_overload,
    input  logic              over_current,
    input  logic              out_short,
    input  logic              temp_hot,
    input  logic              temp_cooled,
    output logic              switch_en,
    output logic              startup_en,
    output logic              halted,
    output logic [CODE_W-1:0] fault_code
);
    logic        any_fault;
    logic        therm_lock;
    fault_code_t cause;
    fault_code_t code_q;
    sup_state_t  state;

    rsup_fault_prio u_prio (
        .fb_overload  (fb_overload),
        .vcc_ovp      (vcc_ovp),
        .over_current (over_current),
        .out_short    (out_short),
        .temp_hot     (temp_hot),
        .any_fault    (any_fault),
        .cause        (cause)
    );

    rsup_therm_lock u_therm (
        .clk         (clk),
        .rst_n       (rst_n),
        .temp_hot    (temp_hot),
        .temp_cooled (temp_cooled),
        .lock        (therm_lock)
    );

    rsup_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .vcc_start  (vcc_start),
        .vcc_stop   (vcc_stop),
        .any_fault  (any_fault),
        .cause      (cause),
        .therm_lock (therm_lock),
        .state      (state),
        .code_q     (code_q)
    );

    // output decode
    always_comb begin
        switch_en  = 1'b0;
        startup_en = 1'b0;
        halted     = 1'b0;
        unique case (state)
            ST_CHARGE: startup_en = 1'b1;
            ST_RUN:    switch_en  = 1'b1;
            ST_HALT:   halted     = 1'b1;
            default:   startup_en = 1'b1;
        endcase
        fault_code = code_q;
    end

    always_comb begin
        if (rst_n) begin
            a_r10_exclusive: assert (!(switch_en && startup_en))
                else $error("R10: switching and start-up source both on");
        end
    end
endmodule

// File: tb/restart_supervisor_tb.sv
module restart_supervisor_tb;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_start = 0, vcc_stop = 0, vcc_ovp = 0, fb_overload = 0;
    logic over_current = 0, out_short = 0, temp_hot = 0, temp_cooled = 0;
    logic switch_en, startup_en, halted;
    logic [2:0] fault_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    restart_supervisor u_dut (
        .clk(clk), .rst_n(rst_n), .vcc_start(vcc_start), .vcc_stop(vcc_stop),
        .vcc_ovp(vcc_ovp), .fb_overload(fb_overload), .over_current(over_current),
        .out_short(out_short), .temp_hot(temp_hot), .temp_cooled(temp_cooled),
        .switch_en(switch_en), .startup_en(startup_en), .halted(halted),
        .fault_code(fault_code)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // state check: {switch_en, startup_en, halted}
    task automatic chk_st(input string req, input int exp_st, input int exp_code);
        chk(req, "state{sw,su,halt}", {switch_en, startup_en, halted}, exp_st);
        chk(req, "fault_code", fault_code, exp_code);
    endtask

    localparam int S_CHG = 3'b010;
    localparam int S_RUN = 3'b100;
    localparam int S_HLT = 3'b001;

    task automatic clear_inputs();
        vcc_start = 0; vcc_stop = 0; vcc_ovp = 0; fb_overload = 0;
        over_current = 0; out_short = 0; temp_hot = 0; temp_cooled = 0;
    endtask

    task automatic do_reset();
        clear_inputs();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic set_fault(input int idx, input logic v);
        case (idx)
            1: fb_overload  = v;
            2: vcc_ovp      = v;
            3: over_current = v;
            4: out_short    = v;
            default: temp_hot = v;
        endcase
    endtask

    task automatic go_run();
        vcc_start = 1; tick(); vcc_start = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk_st("R1", S_CHG, 0);
        tick();
        chk_st("R1", S_CHG, 0);
    endtask

    task automatic t_start_and_uvlo();
        do_reset();
        go_run();
        chk_st("R2", S_RUN, 0);
        tick();
        chk_st("R2", S_RUN, 0);
        vcc_stop = 1; tick(); vcc_stop = 0;
        chk_st("R3", S_CHG, 0);
        go_run();
        chk_st("R2", S_RUN, 0);
    endtask

    task automatic t_each_fault();
        for (int i = 1; i <= 4; i++) begin
            do_reset();
            go_run();
            set_fault(i, 1); tick();
            chk_st("R4", S_HLT, i);
            chk("R6", "cause code", fault_code, i);
            set_fault(i, 0);
            for (int k = 0; k < 3; k++) begin
                tick();
                chk_st("R5", S_HLT, i);
            end
            vcc_stop = 1; tick(); vcc_stop = 0;
            chk_st("R5", S_CHG, i);
            go_run();
            chk_st("R7", S_RUN, 0);
        end
    endtask

    task automatic t_priority();
        do_reset(); go_run();
        fb_overload = 1; out_short = 1; over_current = 1; tick();
        chk_st("R6", S_HLT, 3);
        do_reset(); go_run();
        fb_overload = 1; out_short = 1; tick();
        chk_st("R6", S_HLT, 4);
        do_reset(); go_run();
        vcc_ovp = 1; over_current = 1; tick();
        chk_st("R6", S_HLT, 2);
        do_reset(); go_run();
        vcc_ovp = 1; temp_hot = 1; tick();
        chk_st("R6", S_HLT, 5);
    endtask

    task automatic t_fault_beats_stop();
        do_reset(); go_run();
        over_current = 1; vcc_stop = 1; tick();
        chk_st("R3", S_HLT, 3);
    endtask

    task automatic t_ignored();
        do_reset();
        fb_overload = 1; vcc_ovp = 1; over_current = 1; out_short = 1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk_st("R8", S_CHG, 0);
        end
        clear_inputs();
        go_run();
        chk_st("R8", S_RUN, 0);
        // flags during HALT leave code and state alone
        fb_overload = 1; tick(); fb_overload = 0;
        chk_st("R4", S_HLT, 1);
        vcc_ovp = 1; over_current = 1; tick();
        chk_st("R7", S_HLT, 1);
        clear_inputs();
        vcc_stop = 1; tick(); vcc_stop = 0;
        chk_st("R8", S_CHG, 1);
    endtask

    task automatic t_thermal();
        do_reset(); go_run();
        temp_hot = 1; tick(); temp_hot = 0;
        chk_st("R4", S_HLT, 5);
        vcc_stop = 1; tick(); vcc_stop = 0;
        chk_st("R5", S_CHG, 5);
        vcc_start = 1; tick(); vcc_start = 0;
        chk_st("R9", S_HLT, 5);
        vcc_stop = 1; tick(); vcc_stop = 0;
        chk_st("R9", S_CHG, 5);
        temp_cooled = 1; temp_hot = 1; tick(); temp_hot = 0; temp_cooled = 0;
        vcc_start = 1; tick(); vcc_start = 0;
        chk_st("R9", S_HLT, 5);
        vcc_stop = 1; tick(); vcc_stop = 0;
        temp_cooled = 1; tick(); temp_cooled = 0;
        chk_st("R9", S_CHG, 5);
        go_run();
        chk_st("R9", S_RUN, 0);
        // hot while charging, no prior code
        do_reset();
        temp_hot = 1; tick(); temp_hot = 0;
        chk_st("R9", S_CHG, 0);
        vcc_start = 1; tick(); vcc_start = 0;
        chk_st("R9", S_HLT, 5);
    endtask

    initial begin
        t_reset();
        t_start_and_uvlo();
        t_each_fault();
        t_priority();
        t_fault_beats_stop();
        t_ignored();
        t_thermal();
        chk("R10", "exclusive outputs", int'(switch_en & startup_en), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule